// File: doc/BRIEF.md
# Four-Wire Serial Register Slave

This block is the slave end of a four-wire host control port in front of a file of thirty-two 8-bit control registers. The host lowers an active-low select, toggles a serial clock and sends 16-bit frames on the data input. Every frame starts with a device code, a direction flag and a register index, and ends with a data byte. Write frames update the addressed register. Read frames return the register contents on a serial output. That output is presented as a data bit plus an output-enable, so the pad driver outside the block can float the line. All four serial pins are synchronised into the system clock domain. The system clock must run at least eight times faster than the serial clock, which may reach 5 MHz.

Some register bits are decoded into active-low enables for the transmitter, voltage reference, ADC, DAC, oscillator and PLL sections. A low level on an enable means the section is running. A high level means it is powered down. An active-low hard reset input puts every register back to its default and holds every enable in the powered-down state while it is low. Power-down written through the registers never clears the register file.

Top module: `serial_regfile_port`

## Requirements
- R1: A frame is 16 bits, sent MSB first: a 2-bit device code, a direction flag (1 = write), a 5-bit register index, then 8 data bits. When the device code is 00 and the flag is 1, the data byte is stored into the indexed register on the 16th rising serial clock edge after select falls.
- R2: In a read frame (device code 00, flag 0), the output-enable stays low during the first 8 bit slots. From the falling serial clock edge that ends slot 7, it goes high and the output carries the register byte MSB first, with each bit launched on a falling edge, so the host can sample it on the following rising edge.
- R3: The output-enable is low whenever select has been high for 3 system clocks or more, and it is low out of reset.
- R4: A frame whose device code is not 00 changes no register and never raises the output-enable.
- R5: A frame that select ends before the 16th rising edge is discarded and changes no register.
- R6: While the hard reset input is low, all six enable outputs are high. Once it is released, every register holds its default: register 1 = 0x02 and all other registers = 0x00. The synchronous system reset has the same effect on the registers.
- R7: Register 0 holds the section power bits: bit 0 transmitter, bit 1 reference, bit 2 ADC, bit 3 DAC. A 1 runs the section, which drives its enable low. Changing these bits leaves every other register unchanged.
- R8: Register 1 bits [1:0] hold the clock mode. Mode 00 powers down the oscillator (its enable high), mode 01 powers down the PLL, and modes 10 and 11 run both. The oscillator and PLL enables are never both high outside hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| hard_rst_n | input | 1 | Active-low hard reset: restores register defaults and forces power-down |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Output-enable for the serial data pad |
| tx_en_n | output | 1 | Transmitter enable, active low |
| vref_en_n | output | 1 | Reference enable, active low |
| adc_en_n | output | 1 | ADC enable, active low |
| dac_en_n | output | 1 | DAC enable, active low |
| osc_en_n | output | 1 | Oscillator enable, active low |
| pll_en_n | output | 1 | PLL enable, active low |

## Verification
Each serial pin passes through two synchronising flops and one edge-detect flop. A host clock edge therefore acts on the third system clock after the pin changes: a write lands in its register, and the enable outputs follow in that same cycle. A read bit appears on the output three clocks after the falling edge that launches it, and the output-enable drops three clocks after select rises. The hard reset forces the enables combinationally and clears the registers at the next clock. The bench holds every serial level for ten system clocks and samples the read data just before each rising serial edge. It compares the enable outputs with its own register model on every clock, but only after all inputs have been still for five clocks, so a comparison never falls inside the three-cycle latency.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int DEV_W      = 2;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int HDR_BITS   = DEV_W + 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int SH_W       = ((HDR_BITS > DATA_W) ? HDR_BITS : DATA_W) - 1;

    localparam logic [DEV_W-1:0]  OWN_DEV   = '0;
    localparam logic [ADDR_W-1:0] REG_POWER = 5'd0;
    localparam logic [ADDR_W-1:0] REG_CLOCK = 5'd1;

    localparam int BIT_TX   = 0;
    localparam int BIT_VREF = 1;
    localparam int BIT_ADC  = 2;
    localparam int BIT_DAC  = 3;

    typedef enum logic [1:0] {
        CM_OSC_OFF = 2'b00,
        CM_PLL_OFF = 2'b01,
        CM_RUN     = 2'b10,
        CM_RUN_ALT = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic tx;
        logic vref;
        logic adc;
        logic dac;
        logic osc;
        logic pll;
    } en_n_t;

    localparam en_n_t ALL_DOWN = '1;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        if (idx == int'(REG_CLOCK)) return {{(DATA_W-2){1'b0}}, CM_RUN};
        return '0;
    endfunction

    function automatic en_n_t decode_power(input logic [DATA_W-1:0] pwr,
                                           input logic [DATA_W-1:0] ck);
        en_n_t     e;
        clk_mode_e m;
        m      = clk_mode_e'(ck[1:0]);
        e.tx   = ~pwr[BIT_TX];
        e.vref = ~pwr[BIT_VREF];
        e.adc  = ~pwr[BIT_ADC];
        e.dac  = ~pwr[BIT_DAC];
        e.osc  = (m == CM_OSC_OFF);
        e.pll  = (m == CM_PLL_OFF);
        return e;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int          N    = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= INIT[g];
                s2 <= INIT[g];
                s3 <= INIT[g];
            end else begin
                s1 <= din[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level[g] = s2;
        assign rise[g]  = s2 & ~s3;
        assign fall[g]  = ~s2 & s3;
    end
endmodule

// File: rtl/srp_frame.sv
module srp_frame
    import srp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_hi,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                sdi_s,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                sdo,
    output logic                sdo_en,
    output logic [CNT_W-1:0]    bit_cnt
);
    logic [SH_W-1:0]   shreg;
    hdr_t              hdr_q;
    hdr_t              hdr_now;
    logic              rd_go;
    logic [DATA_W-1:0] out_sh;
    logic              hdr_slot;
    logic              last_slot;

    assign hdr_now   = hdr_t'({shreg[HDR_BITS-2:0], sdi_s});
    assign hdr_slot  = (bit_cnt == CNT_W'(HDR_BITS - 1));
    assign last_slot = (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign rd_addr   = hdr_now.addr;

    assign wr_en   = sck_rise && !cs_hi && last_slot &&
                     hdr_q.dev == OWN_DEV && hdr_q.wr;
    assign wr_addr = hdr_q.addr;
    assign wr_data = {shreg[DATA_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst || cs_hi) begin
            bit_cnt <= '0;
            shreg   <= '0;
            hdr_q   <= '0;
            rd_go   <= 1'b0;
            out_sh  <= '0;
            sdo_en  <= 1'b0;
        end else begin
            if (sck_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
                shreg   <= {shreg[SH_W-2:0], sdi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (hdr_slot) begin
                    hdr_q  <= hdr_now;
                    rd_go  <= (hdr_now.dev == OWN_DEV) && !hdr_now.wr;
                    out_sh <= rd_data;
                end
            end
            if (sck_fall && rd_go && bit_cnt >= CNT_W'(HDR_BITS)) begin
                if (!sdo_en) sdo_en <= 1'b1;
                else         out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign sdo = sdo_en & out_sh[DATA_W-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] pwr_byte,
    output logic [DATA_W-1:0] clk_byte
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || !hard_rst_n)
                regs[g] <= reg_default(g);
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
    end

    assign rd_data  = regs[rd_addr];
    assign pwr_byte = regs[REG_POWER];
    assign clk_byte = regs[REG_CLOCK];
endmodule

// File: rtl/srp_power.sv
module srp_power
    import srp_pkg::*;
(
    input  logic              hard_rst_n,
    input  logic [DATA_W-1:0] pwr_byte,
    input  logic [DATA_W-1:0] clk_byte,
    output en_n_t             en_n
);
    always_comb begin
        if (!hard_rst_n) en_n = ALL_DOWN;
        else             en_n = decode_power(pwr_byte, clk_byte);
    end
endmodule

// File: rtl/serial_regfile_port.sv
module serial_regfile_port
    import srp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hard_rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en,
    output logic tx_en_n,
    output logic vref_en_n,
    output logic adc_en_n,
    output logic dac_en_n,
    output logic osc_en_n,
    output logic pll_en_n
);
    logic [2:0]        lvl, rse, fll;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data, pwr_byte, clk_byte;
    logic              wr_en;
    logic [CNT_W-1:0]  bit_cnt;
    en_n_t             en_n;

    srp_sync #(.N(3), .INIT(3'b011)) u_sync (
        .clk(clk), .rst(rst), .din({sdi, sclk, cs_n}),
        .level(lvl), .rise(rse), .fall(fll)
    );

    srp_frame u_frame (
        .clk(clk), .rst(rst), .cs_hi(lvl[0]),
        .sck_rise(rse[1]), .sck_fall(fll[1]), .sdi_s(lvl[2]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_en(sdo_en), .bit_cnt(bit_cnt)
    );

    srp_regfile u_regs (
        .clk(clk), .rst(rst), .hard_rst_n(hard_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pwr_byte(pwr_byte), .clk_byte(clk_byte)
    );

    srp_power u_pwr (
        .hard_rst_n(hard_rst_n), .pwr_byte(pwr_byte),
        .clk_byte(clk_byte), .en_n(en_n)
    );

    assign tx_en_n   = en_n.tx;
    assign vref_en_n = en_n.vref;
    assign adc_en_n  = en_n.adc;
    assign dac_en_n  = en_n.dac;
    assign osc_en_n  = en_n.osc;
    assign pll_en_n  = en_n.pll;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hard_rst_n,
    input logic             cs_n,
    input logic             sdo_en,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [5:0]       en_vec
);
    logic [2:0] cs_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cs_n)          cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    AST_OE_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= 3'd4) |-> !sdo_en);                              // R3

    AST_OE_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> (bit_cnt >= CNT_W'(HDR_BITS)));                      // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS));                                 // R1

    AST_HRST_PWRDN: assert property (@(posedge clk) disable iff (rst)
        !hard_rst_n |-> (en_vec == 6'h3F));                             // R6

    AST_CM_EXCL: assert property (@(posedge clk) disable iff (rst)
        hard_rst_n |-> !(en_vec[1] && en_vec[0]));                      // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_cnt >= 3'd4 && hard_rst_n) |=> (!hard_rst_n || $stable(en_vec))); // R5
endmodule

bind serial_regfile_port srp_checker u_chk (
    .clk(clk), .rst(rst), .hard_rst_n(hard_rst_n), .cs_n(cs_n),
    .sdo_en(sdo_en), .bit_cnt(bit_cnt),
    .en_vec({tx_en_n, vref_en_n, adc_en_n, dac_en_n, osc_en_n, pll_en_n})
);

// File: tb/serial_regfile_port_test.sv
module serial_regfile_port_test;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hard_rst_n = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic sdo, sdo_en, tx_en_n, vref_en_n, adc_en_n, dac_en_n, osc_en_n, pll_en_n;

    int checks = 0, fails = 0, quiet = 0;
    logic [7:0] model [32];
    logic prev_cs = 1'b1, prev_sck = 1'b1, prev_hr = 1'b1;
    bit   done = 0;

    always #5 clk = ~clk;

    serial_regfile_port uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_en();
        logic [5:0] e;
        if (!hard_rst_n) return 6'h3F;
        e[5] = ~model[0][0]; e[4] = ~model[0][1];
        e[3] = ~model[0][2]; e[2] = ~model[0][3];
        e[1] = (model[1][1:0] == 2'b00);
        e[0] = (model[1][1:0] == 2'b01);
        return e;
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 32; i++) model[i] = (i == 1) ? 8'h02 : 8'h00;
    endtask

    // R7: every-clock comparison of the enable outputs once inputs are still
    always @(negedge clk) begin
        if (cs_n != prev_cs || sclk != prev_sck || hard_rst_n != prev_hr || rst) quiet = 0;
        else quiet++;
        prev_cs = cs_n; prev_sck = sclk; prev_hr = hard_rst_n;
        if (quiet >= 5 && !done)
            chk("R7 per-clock enables",
                {26'd0, tx_en_n, vref_en_n, adc_en_n, dac_en_n, osc_en_n, pll_en_n},
                {26'd0, exp_en()});
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] dev, input logic wr, input logic [4:0] addr,
                         input logic [7:0] data, input int nbits, output logic [7:0] rd);
        logic [15:0] w;
        bit ok_read;
        w = {dev, wr, addr, data};
        ok_read = (dev == 2'b00) && !wr && nbits == 16;
        rd = 8'h00;
        cs_n = 1'b0;
        waitc(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = w[15-i];
            waitc(HALF);
            if (i < 8)             chk("R2 oe low in header", {31'd0, sdo_en}, 32'd0);
            else if (ok_read) begin
                chk("R2 oe high in data", {31'd0, sdo_en}, 32'd1);
                rd = {rd[6:0], sdo};
            end else if (dev != 2'b00)
                chk("R4 oe low for foreign device", {31'd0, sdo_en}, 32'd0);
            sclk = 1'b1;
            if (i == 15 && dev == 2'b00 && wr) model[addr] = data;
            waitc(HALF);
        end
        cs_n = 1'b1;
        waitc(6);
        chk("R3 oe low after select high", {31'd0, sdo_en}, 32'd0);
    endtask

    task automatic rd_check(input string req, input logic [4:0] a);
        logic [7:0] v;
        frame(2'b00, 1'b0, a, 8'h00, 16, v);
        chk(req, {24'd0, v}, {24'd0, model[a]});
    endtask

    initial begin
        logic [7:0] dummy;
        model_defaults();
        waitc(4);
        rst = 1'b0;
        waitc(6);
        chk("R3 oe low out of reset", {31'd0, sdo_en}, 32'd0);
        chk("R6 reset enables", {26'd0, tx_en_n, vref_en_n, adc_en_n, dac_en_n, osc_en_n, pll_en_n}, 32'h3C);
        rd_check("R6 default reg1", 5'd1);

        frame(2'b00, 1'b1, 5'd0, 8'h0F, 16, dummy);
        rd_check("R1 readback reg0", 5'd0);
        frame(2'b00, 1'b1, 5'd0, 8'h05, 16, dummy);
        chk("R7 tx/vref/adc/dac mapping", {28'd0, tx_en_n, vref_en_n, adc_en_n, dac_en_n}, 32'h5);
        rd_check("R7 reg1 untouched by power bits", 5'd1);

        frame(2'b00, 1'b1, 5'd7, 8'hA5, 16, dummy);
        frame(2'b00, 1'b1, 5'd31, 8'h3C, 16, dummy);
        rd_check("R1 readback reg7", 5'd7);
        rd_check("R2 readback reg31", 5'd31);

        frame(2'b10, 1'b1, 5'd7, 8'hFF, 16, dummy);
        frame(2'b01, 1'b0, 5'd7, 8'h00, 16, dummy);
        rd_check("R4 foreign device write ignored", 5'd7);

        frame(2'b00, 1'b1, 5'd7, 8'h11, 12, dummy);
        rd_check("R5 aborted frame at 12 bits", 5'd7);
        frame(2'b00, 1'b1, 5'd7, 8'h22, 15, dummy);
        rd_check("R5 aborted frame at 15 bits", 5'd7);

        frame(2'b00, 1'b1, 5'd1, 8'h00, 16, dummy);
        chk("R8 mode 00 osc down", {30'd0, osc_en_n, pll_en_n}, 32'h2);
        frame(2'b00, 1'b1, 5'd1, 8'h01, 16, dummy);
        chk("R8 mode 01 pll down", {30'd0, osc_en_n, pll_en_n}, 32'h1);
        frame(2'b00, 1'b1, 5'd1, 8'h03, 16, dummy);
        chk("R8 mode 11 both run", {30'd0, osc_en_n, pll_en_n}, 32'h0);

        hard_rst_n = 1'b0;
        waitc(2);
        chk("R6 enables forced in hard reset",
            {26'd0, tx_en_n, vref_en_n, adc_en_n, dac_en_n, osc_en_n, pll_en_n}, 32'h3F);
        model_defaults();
        waitc(4);
        hard_rst_n = 1'b1;
        waitc(6);
        rd_check("R6 reg7 default after hard reset", 5'd7);
        rd_check("R6 reg0 default after hard reset", 5'd0);
        rd_check("R6 reg1 default after hard reset", 5'd1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule